// File: doc/BRIEF.md
# Prioritized Interrupt Request Arbiter

This block gathers level-sensitive interrupt requests from a parameterized set of device lines, plus one request bit that software writes. It filters them through a per-source enable mask and selects the single highest-ranked pending request. The result is one registered interrupt line to the processor, together with an encoded number that names the winning source.

The processor also provides a global disable level, which silences every maskable source. A non-maskable request line bypasses the mask and the global disable, and it outranks everything else. A small write port, made of a one-bit register select, a write strobe and a data word, loads the mask and sets or clears the software request bit.

Source numbering is fixed. The software bit is source 0 and device line k is source k+1. A higher source number wins. The reported ID is the source number plus one. ID 0 means nothing is pending, and the all-ones ID is reserved for the non-maskable request.

Top module: `irq_arbiter`

## Requirements
- R1: After reset, the mask and the software bit are zero, irq_o is low and id_o is zero.
- R2: A source whose mask bit is 0 never raises irq_o and is never reported. If the whole mask is zero and nmi_i is low, irq_o stays low.
- R3: Among the pending sources whose mask bit is set, the source with the highest number wins. id_o is that number plus one, so device k reports k+2 and the software bit reports 1.
- R4: A write with addr_i=1 loads the software request bit from wdata_i[0], which sets or clears it. The bit acts as source 0.
- R5: While gdis_i is high and nmi_i is low, irq_o is low and id_o is zero.
- R6: While nmi_i is high, irq_o is high and id_o is all ones, whatever the mask and gdis_i hold.
- R7: irq_o and id_o are registered. They reflect the inputs sampled at the previous rising clock edge, and a register write becomes visible one edge after the write edge.
- R8: With no enabled request pending and nmi_i low, irq_o is low and id_o is zero.
- R9: When we_i is low, addr_i and wdata_i have no effect on the mask or on the software bit.
- R10: A write with addr_i=0 loads the mask from wdata_i. Bit 0 enables the software bit and bit k+1 enables device k.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| dev_req_i | input | N_DEV | Level-sensitive device requests |
| we_i | input | 1 | Register write strobe |
| addr_i | input | 1 | Register select: 0 selects the mask, 1 selects the software bit |
| wdata_i | input | N_DEV+1 | Write data |
| gdis_i | input | 1 | Global disable of the maskable sources |
| nmi_i | input | 1 | Non-maskable request |
| irq_o | output | 1 | Interrupt to the processor |
| id_o | output | IDW | Encoded identity of the winning source |

## Verification
All device lines are raised under a partial mask, so the reported ID shows whether ranking looks only at enabled sources. A sparse request pattern under a full mask separates highest-number-wins from lowest-number-wins. The software bit is exercised alone, which shows that it takes part as the lowest-ranked source. Global disable and the non-maskable line are driven together against a zero mask, so the bypass of both masking levels can be told apart from an ordinary win. A dropped write strobe and an input change observed just before the next edge expose unintended register updates and combinational leakage.

// File: rtl/irq_arbiter_pkg.sv
package irq_arbiter_pkg;
  typedef enum logic {
    SEL_MASK = 1'b0,
    SEL_SOFT = 1'b1
  } reg_sel_e;
endpackage

// File: rtl/irq_src_regs.sv
module irq_src_regs #(
  parameter int NSRC = 5
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            we_i,
  input  logic            addr_i,
  input  logic [NSRC-1:0] wdata_i,
  output logic [NSRC-1:0] mask_o,
  output logic            soft_o
);
  import irq_arbiter_pkg::*;

  reg_sel_e sel;
  assign sel = reg_sel_e'(addr_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mask_o <= '0;
      soft_o <= 1'b0;
    end else if (we_i) begin
      if (sel == SEL_MASK) mask_o <= wdata_i;
      else                 soft_o <= wdata_i[0];
    end
  end
endmodule

// File: rtl/irq_prio_enc.sv
module irq_prio_enc #(
  parameter int NSRC = 5,
  parameter int IDW  = 3
) (
  input  logic [NSRC-1:0] req_i,
  output logic            valid_o,
  output logic [IDW-1:0]  id_o
);
  logic [NSRC-1:0] win;

  // a source wins when no higher-numbered source requests
  for (genvar i = 0; i < NSRC; i++) begin : g_win
    if (i == NSRC - 1) begin : g_top
      assign win[i] = req_i[i];
    end else begin : g_low
      assign win[i] = req_i[i] & ~(|req_i[NSRC-1:i+1]);
    end
  end

  assign valid_o = |req_i;

  always_comb begin
    id_o = '0;
    for (int i = 0; i < NSRC; i++) begin
      if (win[i]) id_o = id_o | IDW'(i + 1);
    end
  end

  // R3
  always_comb begin
    win_onehot_chk: assert ($onehot0(win));
  end
endmodule

// File: rtl/irq_arbiter.sv
module irq_arbiter #(
  parameter  int N_DEV = 4,
  localparam int NSRC  = N_DEV + 1,
  localparam int IDW   = $clog2(NSRC + 2)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [N_DEV-1:0] dev_req_i,
  input  logic             we_i,
  input  logic             addr_i,
  input  logic [NSRC-1:0]  wdata_i,
  input  logic             gdis_i,
  input  logic             nmi_i,
  output logic             irq_o,
  output logic [IDW-1:0]   id_o
);
  localparam logic [IDW-1:0] NMI_ID = '1;

  logic [NSRC-1:0] mask_q;
  logic            soft_q;
  logic [NSRC-1:0] req_en;
  logic            enc_valid;
  logic [IDW-1:0]  enc_id;

  irq_src_regs #(.NSRC(NSRC)) u_regs (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .we_i   (we_i),
    .addr_i (addr_i),
    .wdata_i(wdata_i),
    .mask_o (mask_q),
    .soft_o (soft_q)
  );

  assign req_en = {dev_req_i, soft_q} & mask_q;

  irq_prio_enc #(.NSRC(NSRC), .IDW(IDW)) u_enc (
    .req_i  (req_en),
    .valid_o(enc_valid),
    .id_o   (enc_id)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      irq_o <= 1'b0;
      id_o  <= '0;
    end else if (nmi_i) begin
      irq_o <= 1'b1;
      id_o  <= NMI_ID;
    end else if (gdis_i || !enc_valid) begin
      irq_o <= 1'b0;
      id_o  <= '0;
    end else begin
      irq_o <= 1'b1;
      id_o  <= enc_id;
    end
  end

  // one edge out of reset before past-based checks apply
  logic chk_armed;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) chk_armed <= 1'b0;
    else         chk_armed <= 1'b1;
  end

  // R6
  nmi_bypass_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    chk_armed && $past(nmi_i) |-> irq_o && id_o == NMI_ID);

  // R5
  gdis_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    chk_armed && $past(gdis_i && !nmi_i) |-> !irq_o && id_o == '0);

  // R2
  zero_mask_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    chk_armed && $past(mask_q == '0 && !nmi_i) |-> !irq_o);

  // R8
  idle_id_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !irq_o |-> id_o == '0);
endmodule

// File: tb/irq_arbiter_test.sv
module irq_arbiter_test;
  localparam int N_DEV = 4;
  localparam int NSRC  = N_DEV + 1;
  localparam int IDW   = $clog2(NSRC + 2);

  logic             clk_i = 1'b0;
  logic             rst_ni = 1'b0;
  logic [N_DEV-1:0] dev_req_i = '0;
  logic             we_i = 1'b0;
  logic             addr_i = 1'b0;
  logic [NSRC-1:0]  wdata_i = '0;
  logic             gdis_i = 1'b0;
  logic             nmi_i = 1'b0;
  logic             irq_o;
  logic [IDW-1:0]   id_o;

  int checks = 0;
  int failures = 0;

  irq_arbiter #(.N_DEV(N_DEV)) uut (.*);

  always #5 clk_i = ~clk_i;

  // behavioural reference
  logic [NSRC-1:0] m_mask;
  logic            m_soft;
  logic            e_irq;
  int              e_id;

  function automatic int ref_id();
    if (nmi_i) return (1 << IDW) - 1;
    if (gdis_i) return 0;
    for (int s = NSRC - 1; s >= 0; s--) begin
      if (m_mask[s] && ((s == 0) ? m_soft : dev_req_i[s-1])) return s + 1;
    end
    return 0;
  endfunction

  always @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      m_mask <= '0; m_soft <= 1'b0; e_irq <= 1'b0; e_id <= 0;
    end else begin
      e_id  <= ref_id();
      e_irq <= (ref_id() != 0);
      if (we_i) begin
        if (addr_i) m_soft <= wdata_i[0];
        else        m_mask <= wdata_i;
      end
    end
  end

  task automatic check(string tag, int exp_irq, int exp_id);
    checks++;
    if (irq_o !== exp_irq[0] || int'(id_o) != exp_id) begin
      failures++;
      $display("FAIL %s irq=%0d id=%0d expected irq=%0d id=%0d", tag, irq_o, id_o, exp_irq, exp_id);
    end
  endtask

  // R7: every cycle must match the one-edge-delayed reference
  always @(negedge clk_i) if (rst_ni) check("R7", int'(e_irq), e_id);

  task automatic write_reg(logic a, logic [NSRC-1:0] d);
    @(negedge clk_i); we_i = 1'b1; addr_i = a; wdata_i = d;
    @(negedge clk_i); we_i = 1'b0;
  endtask

  task automatic settle();
    @(negedge clk_i); @(negedge clk_i);
  endtask

  initial begin
    #1 check("R1", 0, 0);
    #20 rst_ni = 1'b1;
    @(negedge clk_i); check("R1", 0, 0);

    dev_req_i = '1; settle(); check("R2", 0, 0);

    write_reg(1'b0, 5'b00110); settle(); check("R10", 1, 3);
    check("R3", 1, 3);

    write_reg(1'b0, '1); dev_req_i = 4'b0101; settle(); check("R3", 1, 4);

    dev_req_i = '0; write_reg(1'b1, 5'b00001); settle(); check("R4", 1, 1);
    write_reg(1'b1, 5'b00000); settle(); check("R4", 0, 0);
    check("R8", 0, 0);

    dev_req_i = '1; gdis_i = 1'b1; settle(); check("R5", 0, 0);
    write_reg(1'b0, '0); nmi_i = 1'b1; settle(); check("R6", 1, 7);
    nmi_i = 1'b0; gdis_i = 1'b0; settle(); check("R2", 0, 0);

    write_reg(1'b0, 5'b10000);
    @(negedge clk_i); addr_i = 1'b0; wdata_i = '0; we_i = 1'b0;
    @(negedge clk_i); addr_i = 1'b1; wdata_i = 5'b00001;
    settle(); check("R9", 1, 5);
    dev_req_i = '0; settle(); check("R9", 0, 0);

    @(negedge clk_i); dev_req_i = 4'b1000;
    #3 check("R7", 0, 0);
    @(negedge clk_i); check("R7", 1, 5);

    settle();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #2000000;
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule